// File: doc/BRIEF.md
# Selectable Clock Output Controller

This block produces a square-wave clock for an output pad from a reference that runs at twice the oscillator rate. With the default parameters, bit 0 of a 16-bit divider toggles at 32768 Hz, bit 5 at 1024 Hz and bit 15 at 1 Hz. A two-bit select register picks one of these three sources or turns the output off. A stop register freezes the slow stages of the divider. A low-supply input from the power supervisor releases the pad. The block drives the pad's data and output-enable and does not contain the pad itself.

The divider is split at the stage above the 1024 Hz tap. The stages below the split run at all times, so the 32768 Hz and 1024 Hz sources are not affected by stop. The stages above the split hold their count while stop is set. Changes of the select value are applied by a handover stage. It moves to the new source only in a cycle where both the old and the new source are low, so the pin never shows a shortened high pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: Select code 00 outputs the fastest tap, bit 0, which toggles on every reference cycle, so each high phase lasts 1 cycle.
- R2: Select code 01 outputs the divider bit MID_TAP, whose high phase lasts 2^MID_TAP cycles.
- R3: Select code 10 outputs the top divider bit, CNT_W-1, whose high phase lasts 2^(CNT_W-1) cycles while stop is 0.
- R4: Select code 11 turns the output off: clk_oe_o is 0 and clk_out_o is 0.
- R5: After reset the select register reads 00, the stop register reads 0 and the pin is enabled and running at the fastest rate.
- R6: While stop is 1, codes 00 and 01 keep their rates and their enable. Code 10 gives clk_oe_o = 0 and clk_out_o = 0.
- R7: Stop freezes the divider stages above bit MID_TAP. When stop is released, the slow output resumes at the phase it held, with no restart.
- R8: While low_supply_i is 1, clk_oe_o is 0 in the same cycle and clk_out_o is 0 from the next cycle onward.
- R9: A change of select takes effect only in a cycle where the old and the new source are both low. The pin shows no high pulse shorter than the high phase of the source that produces it.
- R10: sel_o and stop_o read back the values last written through their write strobes. Writing both strobes in the same cycle updates both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the oscillator rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Write strobe for the select register |
| sel_wdata_i | input | 2 | Select value: 00 fast, 01 mid, 10 slow, 11 off |
| stop_we_i | input | 1 | Write strobe for the stop register |
| stop_wdata_i | input | 1 | Stop value; 1 freezes the upper divider stages |
| low_supply_i | input | 1 | Supply below threshold, from the supervisor |
| sel_o | output | 2 | Select register readback |
| stop_o | output | 1 | Stop register readback |
| clk_out_o | output | 1 | Pad data |
| clk_oe_o | output | 1 | Pad output enable; 0 means high impedance |

## Verification
A select write and a stop write can land in the same cycle. The handover to the slow source can then complete while that source is already gated. The bench writes select 10 and stop 1 with both strobes in one cycle. It checks that the pin stays disabled and low, and that releasing stop alone then gives the full slow high phase. A second collision is a handover in progress while the divider is frozen. The random phase mixes select and stop writes and checks the enable and the measured high phase after each mix.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    SEL_FAST = 2'b00,
    SEL_MID  = 2'b01,
    SEL_SLOW = 2'b10,
    SEL_OFF  = 2'b11
  } fsel_e;
endpackage

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int CNT_W   = 16,
  parameter int MID_TAP = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic tap_fast_o,
  output logic tap_mid_o,
  output logic tap_slow_o
);
  localparam int HOLD_LO = MID_TAP + 1;
  localparam int HI_W    = CNT_W - HOLD_LO;

  logic [HOLD_LO-1:0] lo_q;
  logic [HI_W-1:0]    hi_q;

  // lower stages always run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else         lo_q <= lo_q + 1'b1;
  end

  // upper stages advance on carry, frozen by stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hi_q <= '0;
    else if (&lo_q && !stop_i)     hi_q <= hi_q + 1'b1;
  end

  assign tap_fast_o = lo_q[0];
  assign tap_mid_o  = lo_q[MID_TAP];
  assign tap_slow_o = hi_q[HI_W-1];

  p_fast_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tap_fast_o != $past(tap_fast_o));
  p_hold_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(hi_q));
endmodule

// File: rtl/clkout_sel.sv
module clkout_sel
  import clkout_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tap_fast_i,
  input  logic  tap_mid_i,
  input  logic  tap_slow_i,
  input  logic  stop_i,
  input  logic  low_i,
  input  fsel_e req_sel_i,
  output fsel_e act_sel_o,
  output logic  out_o
);
  fsel_e act_q;
  logic  out_q;
  logic  src_cur, src_new, swap;

  function automatic logic pick(fsel_e s, logic f, logic m, logic sl, logic st);
    case (s)
      SEL_FAST: pick = f;
      SEL_MID:  pick = m;
      SEL_SLOW: pick = sl & ~st;
      default:  pick = 1'b0;
    endcase
  endfunction

  assign src_cur = pick(act_q,     tap_fast_i, tap_mid_i, tap_slow_i, stop_i);
  assign src_new = pick(req_sel_i, tap_fast_i, tap_mid_i, tap_slow_i, stop_i);
  assign swap    = (act_q != req_sel_i) && !src_cur && !src_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= SEL_FAST;
      out_q <= 1'b0;
    end else begin
      if (swap) act_q <= req_sel_i;
      out_q <= !low_i && !swap && src_cur;
    end
  end

  assign act_sel_o = act_q;
  assign out_o     = out_q;

  p_swap_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> !out_q);
  p_low_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> !out_q);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MID_TAP = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_we_i,
  input  logic [1:0] sel_wdata_i,
  input  logic       stop_we_i,
  input  logic       stop_wdata_i,
  input  logic       low_supply_i,
  output logic [1:0] sel_o,
  output logic       stop_o,
  output logic       clk_out_o,
  output logic       clk_oe_o
);
  fsel_e sel_q, act_sel;
  logic  stop_q;
  logic  t_fast, t_mid, t_slow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_FAST;
      stop_q <= 1'b0;
    end else begin
      if (sel_we_i)  sel_q  <= fsel_e'(sel_wdata_i);
      if (stop_we_i) stop_q <= stop_wdata_i;
    end
  end

  clkout_div #(.CNT_W(CNT_W), .MID_TAP(MID_TAP)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_q),
    .tap_fast_o (t_fast),
    .tap_mid_o  (t_mid),
    .tap_slow_o (t_slow)
  );

  clkout_sel i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tap_fast_i (t_fast),
    .tap_mid_i  (t_mid),
    .tap_slow_i (t_slow),
    .stop_i     (stop_q),
    .low_i      (low_supply_i),
    .req_sel_i  (sel_q),
    .act_sel_o  (act_sel),
    .out_o      (clk_out_o)
  );

  assign clk_oe_o = !low_supply_i && (act_sel != SEL_OFF) &&
                    !(act_sel == SEL_SLOW && stop_q);
  assign sel_o    = sel_q;
  assign stop_o   = stop_q;

  p_low_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |-> !clk_oe_o);
  p_stop_slow_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && $past(stop_q) && act_sel == SEL_SLOW && $past(act_sel) == SEL_SLOW)
    |-> !clk_out_o);
  p_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel == SEL_OFF && $past(act_sel) == SEL_OFF) |-> !clk_out_o);
endmodule

// File: tb/test_clkout_ctrl.sv
module test_clkout_ctrl;
  localparam int CNT_W = 10;
  localparam int MID_TAP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_we = 0, stop_we = 0, stop_wd = 0, low = 0;
  logic [1:0] sel_wd = 2'b00;
  logic [1:0] sel_rb;
  logic stop_rb, dout, oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  clkout_ctrl #(.CNT_W(CNT_W), .MID_TAP(MID_TAP)) i_clkout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_wdata_i(sel_wd),
    .stop_we_i(stop_we), .stop_wdata_i(stop_wd), .low_supply_i(low),
    .sel_o(sel_rb), .stop_o(stop_rb), .clk_out_o(dout), .clk_oe_o(oe));

  function automatic int exp_half(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 1 << MID_TAP;
      2'b10: return 1 << (CNT_W - 1);
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_oe(logic [1:0] s, logic st, logic lo);
    return !lo && s != 2'b11 && !(s == 2'b10 && st);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic ws, logic [1:0] s, logic wt, logic t);
    @(posedge clk); #1;
    sel_we = ws; sel_wd = s; stop_we = wt; stop_wd = t;
    @(posedge clk); #1;
    sel_we = 0; stop_we = 0;
  endtask

  task automatic settle();
    repeat (2 * (1 << (CNT_W - 1)) + 8) @(posedge clk);
  endtask

  // length of the next complete high phase, 0 on timeout
  task automatic measure(output int h);
    int n = 0;
    h = 0;
    @(negedge clk);
    while (dout && n < 4000) begin @(negedge clk); n++; end
    while (!dout && n < 4000) begin @(negedge clk); n++; end
    while (dout && n < 4000) begin h++; @(negedge clk); n++; end
    if (n >= 4000) h = 0;
  endtask

  // counts high runs not matching a or b after the first low sample
  task automatic runt_scan(int cycles, int a, int b, output int bad);
    int run = 0;
    bit armed = 0;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!armed) begin
        if (!dout) armed = 1;
      end else if (dout) run++;
      else if (run > 0) begin
        if (run != a && run != b) bad++;
        run = 0;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h, bad;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R5 sel reset", sel_rb, 0);
    chk("R5 stop reset", stop_rb, 0);
    chk("R5 oe reset", oe, 1);
    measure(h); chk("R1 R5 fast half", h, exp_half(2'b00));

    wr(1, 2'b01, 0, 0); settle();
    measure(h); chk("R2 mid half", h, exp_half(2'b01));
    chk("R10 sel readback", sel_rb, 1);

    // R9: mid to slow, then slow to fast
    wr(1, 2'b10, 0, 0);
    runt_scan(1500, exp_half(2'b01), exp_half(2'b10), bad);
    chk("R9 runt mid->slow", bad, 0);
    measure(h); chk("R3 slow half", h, exp_half(2'b10));
    wr(1, 2'b00, 0, 0);
    runt_scan(1500, exp_half(2'b00), exp_half(2'b10), bad);
    chk("R9 runt slow->fast", bad, 0);

    wr(1, 2'b11, 0, 0); settle();
    @(negedge clk);
    chk("R4 off oe", oe, 0); chk("R4 off data", dout, 0);

    // R6: stop leaves fast and mid running
    wr(1, 2'b01, 1, 1); settle();
    chk("R10 stop readback", stop_rb, 1);
    measure(h); chk("R6 mid under stop", h, exp_half(2'b01));
    chk("R6 mid oe under stop", oe, 1);
    wr(1, 2'b00, 0, 0); settle();
    measure(h); chk("R6 fast under stop", h, exp_half(2'b00));
    wr(0, 2'b00, 1, 0); settle();

    // R7: freeze mid-pulse, resume
    wr(1, 2'b10, 0, 0); settle();
    measure(h);
    while (!dout) @(negedge clk);
    repeat (100) @(negedge clk);
    wr(0, 2'b00, 1, 1);
    repeat (300) @(negedge clk);
    chk("R6 slow oe under stop", oe, 0);
    chk("R6 slow data under stop", dout, 0);
    wr(0, 2'b00, 1, 0);
    @(negedge clk); @(negedge clk);
    chk("R7 resume high", dout, 1);
    h = 0;
    while (dout && h < 2000) begin h++; @(negedge clk); end
    chk("R7 remaining phase in window", int'(h > 320 && h < 480), 1);

    // collision: select and stop written in one cycle
    wr(1, 2'b00, 0, 0); settle();
    wr(1, 2'b10, 1, 1); settle();
    chk("R10 both strobes sel", sel_rb, 2);
    chk("R10 both strobes stop", stop_rb, 1);
    @(negedge clk);
    chk("R6 collide oe", oe, 0); chk("R6 collide data", dout, 0);
    wr(0, 2'b00, 1, 0);
    measure(h); chk("R3 after collide", h, exp_half(2'b10));

    // R8 low supply
    wr(1, 2'b00, 0, 0); settle();
    @(negedge clk); low = 1; #1;
    chk("R8 oe same cycle", oe, 0);
    bad = 0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (dout) bad++; end
    chk("R8 data quiet", bad, 0);
    low = 0;
    measure(h); chk("R8 recover", h, 1);

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [1:0] s;
      logic t;
      s = 2'($urandom % 4);
      t = 1'($urandom % 2);
      wr(1, s, 1, t); settle();
      @(negedge clk);
      chk("R10 rand sel", sel_rb, s);
      chk("R4 R6 rand oe", oe, exp_oe(s, t, 0));
      if (exp_oe(s, t, 0)) begin
        measure(h); chk("R1 R2 R3 rand half", h, exp_half(s));
      end else chk("R4 R6 rand data", dout, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule